// File: doc/BRIEF.md
# Software-Generated Interrupt Dispatcher

This block turns a write to a software interrupt request register into pending state for one of `NUM_SGI` software interrupt IDs. The state is kept for each of up to `NUM_CPUS` destination processors. The writing processor gives its own index, and the written word selects an interrupt ID, a filter mode and an explicit destination list.

For every destination that receives the interrupt, the block sets a pending flag. It also records the writer in a source mask for that destination and ID, so the same ID sent by two different processors stays as two separate requests.

A consumer retires requests one source at a time through a clear port. A destination's pending flag for an ID stays set as long as any source bit for that ID remains. Reads of the request register always return zero.

Top module: `sgi_dispatch`

## Requirements
- R1: The written word is decoded as follows: interrupt ID in bits [3:0], destination list in bits [23:16] (bit 16+n selects CPU n), filter mode in bits [25:24]. All other bits have no effect.
- R2: Mode 0 targets the CPUs set in the destination list, restricted to the online CPUs (index below `online_cnt`). A list that selects no online CPU changes nothing.
- R3: Mode 1 targets every online CPU except the writer, and ignores the destination list.
- R4: Mode 2 targets only the writing CPU, and ignores the destination list.
- R5: Mode 3 is reserved; such a write changes no pending flag and no source mask.
- R6: For each targeted destination d and ID i, the pending flag `pend_o[d*NUM_SGI+i]` is set. The writer's bit s is OR'd into `src_mask_o[(d*NUM_SGI+i)*NUM_CPUS+s]`, and source bits already present are kept.
- R7: `rd_data` reads as zero at all times.
- R8: A clear request (`clr_dst`, `clr_id`, `clr_src`) removes exactly that one source bit. The pending flag stays set while any other source bit for that destination and ID remains, and drops in the same cycle the last one is removed.
- R9: When a write sets the same source bit that a clear removes in the same cycle, the bit ends up set and the pending flag stays set.
- R10: After reset, all pending flags and all source masks are zero.
- R11: The effect of a write or a clear is visible on the outputs right after the clock edge that samples it, one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Request register write strobe |
| wr_cpu | input | CPU_W | Index of the writing CPU |
| wr_data | input | 32 | Written word |
| online_cnt | input | CNT_W | Number of online CPUs (1..NUM_CPUS) |
| rd_data | output | 32 | Read value of the request register (always zero) |
| clr_en | input | 1 | Retire one source bit |
| clr_dst | input | CPU_W | Destination CPU of the bit to retire |
| clr_id | input | ID_W | Interrupt ID of the bit to retire |
| clr_src | input | CPU_W | Source CPU of the bit to retire |
| pend_o | output | NUM_CPUS*NUM_SGI | Pending flags, index dst*NUM_SGI+id |
| src_mask_o | output | NUM_CPUS*NUM_SGI*NUM_CPUS | Source masks, index (dst*NUM_SGI+id)*NUM_CPUS+src |

## Verification
The assertions assume that `online_cnt` is at least one and never exceeds `NUM_CPUS`, and that `wr_cpu` names an online CPU. Under those conditions a mode 2 write always lands on a real destination, and mode 1 never targets a slot that does not exist. The stimulus keeps to this: it holds `online_cnt` fixed within each phase and draws every writer index below it. Clear requests may name any destination, ID or source, including bits that are already zero. Writes and clears are issued together on purpose, so that the same-bit collision case comes up.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int WORD_W   = 32;
    localparam int ID_W     = 4;
    localparam int ID_LSB   = 0;
    localparam int LIST_W   = 8;
    localparam int LIST_LSB = 16;
    localparam int MODE_W   = 2;
    localparam int MODE_LSB = 24;

    typedef enum logic [MODE_W-1:0] {
        SGI_MODE_LIST   = 2'd0,
        SGI_MODE_OTHERS = 2'd1,
        SGI_MODE_SELF   = 2'd2,
        SGI_MODE_RSVD   = 2'd3
    } sgi_mode_e;

    typedef struct packed {
        sgi_mode_e           mode;
        logic [LIST_W-1:0]   list;
        logic [ID_W-1:0]     id;
    } sgi_cmd_t;

    function automatic sgi_cmd_t sgi_unpack(input logic [WORD_W-1:0] word);
        sgi_cmd_t c;
        c.id   = word[ID_LSB +: ID_W];
        c.list = word[LIST_LSB +: LIST_W];
        c.mode = sgi_mode_e'(word[MODE_LSB +: MODE_W]);
        return c;
    endfunction

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8
) (
    input  logic                          wr_en,
    input  logic [$clog2(NUM_CPUS)-1:0]   wr_cpu,
    input  logic [WORD_W-1:0]             wr_data,
    input  logic [$clog2(NUM_CPUS+1)-1:0] online_cnt,
    output logic                          fire_o,
    output logic [ID_W-1:0]               id_o,
    output sgi_mode_e                     mode_o,
    output logic [NUM_CPUS-1:0]           tgt_o
);

    localparam int CNT_W = $clog2(NUM_CPUS+1);

    sgi_cmd_t            cmd;
    logic [NUM_CPUS-1:0] online;
    logic [NUM_CPUS-1:0] self_vec;
    logic [NUM_CPUS-1:0] list_vec;
    logic [NUM_CPUS-1:0] tgt;

    always_comb begin
        cmd      = sgi_unpack(wr_data);
        online   = '0;
        list_vec = '0;
        self_vec = '0;
        for (int c = 0; c < NUM_CPUS; c++) begin
            online[c] = (CNT_W'(c) < online_cnt);
            if (c < LIST_W) begin
                list_vec[c] = cmd.list[c];
            end
        end
        self_vec[wr_cpu] = 1'b1;
        unique case (cmd.mode)
            SGI_MODE_LIST:   tgt = list_vec & online;
            SGI_MODE_OTHERS: tgt = online & ~self_vec;
            SGI_MODE_SELF:   tgt = self_vec;
            default:         tgt = '0;
        endcase
        tgt_o  = wr_en ? tgt : '0;
        fire_o = wr_en && (|tgt);
        id_o   = cmd.id;
        mode_o = cmd.mode;
    end

endmodule

// File: rtl/sgi_src_bank.sv
module sgi_src_bank
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        set_en,
    input  logic [ID_W-1:0]             set_id,
    input  logic [$clog2(NUM_CPUS)-1:0] set_src,
    input  logic                        clr_en,
    input  logic [ID_W-1:0]             clr_id,
    input  logic [$clog2(NUM_CPUS)-1:0] clr_src,
    output logic [NUM_SGI-1:0]          pend_o,
    output logic [NUM_SGI*NUM_CPUS-1:0] mask_o
);

    localparam int CPU_W = $clog2(NUM_CPUS);

    typedef struct packed {
        logic [NUM_SGI-1:0][NUM_CPUS-1:0] mask;
        logic [NUM_SGI-1:0]               pend;
    } bank_t;

    bank_t state_d, state_q;

    always_comb begin
        logic set_b, clr_b, hit;
        state_d = state_q;
        for (int i = 0; i < NUM_SGI; i++) begin
            hit = 1'b0;
            for (int s = 0; s < NUM_CPUS; s++) begin
                set_b = set_en && (set_id == ID_W'(i)) && (set_src == CPU_W'(s));
                clr_b = clr_en && (clr_id == ID_W'(i)) && (clr_src == CPU_W'(s));
                state_d.mask[i][s] = set_b | (state_q.mask[i][s] & ~clr_b);
                hit = hit | set_b;
            end
            state_d.pend[i] = hit | (state_q.pend[i] & (|state_d.mask[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign pend_o = state_q.pend;
    assign mask_o = state_q.mask;

    for (genvar g = 0; g < NUM_SGI; g++) begin : g_chk
        AST_PEND_TRACKS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            state_q.pend[g] == (|state_q.mask[g])); // R8
    end

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> state_q.mask[$past(set_id)][$past(set_src)]); // R6

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && clr_en && set_id == clr_id && set_src == clr_src)
        |=> state_q.pend[$past(set_id)]); // R9

    AST_CLEAR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_id == clr_id && set_src == clr_src))
        |=> !state_q.mask[$past(clr_id)][$past(clr_src)]); // R8

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPUS = 8,
    parameter int NUM_SGI  = 16,
    localparam int CPU_W   = $clog2(NUM_CPUS),
    localparam int CNT_W   = $clog2(NUM_CPUS+1)
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [CPU_W-1:0]                     wr_cpu,
    input  logic [WORD_W-1:0]                    wr_data,
    input  logic [CNT_W-1:0]                     online_cnt,
    output logic [WORD_W-1:0]                    rd_data,
    input  logic                                 clr_en,
    input  logic [CPU_W-1:0]                     clr_dst,
    input  logic [ID_W-1:0]                      clr_id,
    input  logic [CPU_W-1:0]                     clr_src,
    output logic [NUM_CPUS*NUM_SGI-1:0]          pend_o,
    output logic [NUM_CPUS*NUM_SGI*NUM_CPUS-1:0] src_mask_o
);

    localparam int BANK_W = NUM_SGI * NUM_CPUS;

    logic                                 fire;
    logic [ID_W-1:0]                      dec_id;
    sgi_mode_e                            dec_mode;
    logic [NUM_CPUS-1:0]                  dec_tgt;
    logic [NUM_CPUS-1:0][NUM_SGI-1:0]     pend_arr;
    logic [NUM_CPUS-1:0][BANK_W-1:0]      mask_arr;

    sgi_decode #(.NUM_CPUS(NUM_CPUS)) u_decode (
        .wr_en      (wr_en),
        .wr_cpu     (wr_cpu),
        .wr_data    (wr_data),
        .online_cnt (online_cnt),
        .fire_o     (fire),
        .id_o       (dec_id),
        .mode_o     (dec_mode),
        .tgt_o      (dec_tgt)
    );

    for (genvar d = 0; d < NUM_CPUS; d++) begin : g_dst
        sgi_src_bank #(.NUM_CPUS(NUM_CPUS), .NUM_SGI(NUM_SGI)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (fire && dec_tgt[d]),
            .set_id  (dec_id),
            .set_src (wr_cpu),
            .clr_en  (clr_en && (clr_dst == CPU_W'(d))),
            .clr_id  (clr_id),
            .clr_src (clr_src),
            .pend_o  (pend_arr[d]),
            .mask_o  (mask_arr[d])
        );
    end

    assign pend_o     = pend_arr;
    assign src_mask_o = mask_arr;
    assign rd_data    = '0;

    AST_SELF_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_mode == SGI_MODE_SELF)
        |=> pend_arr[$past(wr_cpu)][$past(dec_id)]); // R4

    AST_RSVD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_mode == SGI_MODE_RSVD && !clr_en)
        |=> ($stable(pend_o) && $stable(src_mask_o))); // R5

    AST_EMPTY_LIST_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_mode == SGI_MODE_LIST && wr_data[LIST_LSB +: LIST_W] == '0 && !clr_en)
        |=> $stable(src_mask_o)); // R2

endmodule

// File: tb/test_sgi_dispatch.sv
module test_sgi_dispatch;

    localparam int NC = 8;
    localparam int NS = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [2:0]      wr_cpu = '0;
    logic [31:0]     wr_data = '0;
    logic [3:0]      online_cnt = 4'd4;
    logic [31:0]     rd_data;
    logic            clr_en = 1'b0;
    logic [2:0]      clr_dst = '0;
    logic [3:0]      clr_id = '0;
    logic [2:0]      clr_src = '0;
    logic [NC*NS-1:0]    pend_o;
    logic [NC*NS*NC-1:0] src_mask_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    bit ref_mask [NC][NS][NC];

    always #5 clk = ~clk;

    sgi_dispatch #(.NUM_CPUS(NC), .NUM_SGI(NS)) i_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_data(wr_data),
        .online_cnt(online_cnt), .rd_data(rd_data), .clr_en(clr_en), .clr_dst(clr_dst),
        .clr_id(clr_id), .clr_src(clr_src), .pend_o(pend_o), .src_mask_o(src_mask_o)
    );

    // behavioural reference, updated on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            foreach (ref_mask[d, i, s]) ref_mask[d][i][s] = 1'b0;
        end else begin
            int id, mode, onl;
            bit hit [NC];
            id   = int'(wr_data[3:0]);
            mode = int'(wr_data[25:24]);
            onl  = int'(online_cnt);
            for (int d = 0; d < NC; d++) begin
                hit[d] = 1'b0;
                if (wr_en) begin
                    if (mode == 0) hit[d] = wr_data[16+d] && d < onl;
                    if (mode == 1) hit[d] = d < onl && d != int'(wr_cpu);
                    if (mode == 2) hit[d] = d == int'(wr_cpu);
                end
            end
            if (clr_en) ref_mask[clr_dst][clr_id][clr_src] = 1'b0;
            for (int d = 0; d < NC; d++)
                if (hit[d]) ref_mask[d][id][wr_cpu] = 1'b1;
        end
    end

    function automatic bit ref_pend(int d, int i);
        bit any = 1'b0;
        for (int s = 0; s < NC; s++) any |= ref_mask[d][i][s];
        return any;
    endfunction

    function automatic bit pb(int d, int i);
        return pend_o[d*NS+i];
    endfunction

    function automatic logic [7:0] mb(int d, int i);
        return src_mask_o[(d*NS+i)*NC +: NC];
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ok_p, ok_m;
            ok_p = 1'b1;
            ok_m = 1'b1;
            for (int d = 0; d < NC; d++)
                for (int i = 0; i < NS; i++) begin
                    if (pb(d, i) !== ref_pend(d, i)) ok_p = 1'b0;
                    for (int s = 0; s < NC; s++)
                        if (src_mask_o[(d*NS+i)*NC+s] !== ref_mask[d][i][s]) ok_m = 1'b0;
                end
            chk(ok_p, "R11/R6 pending vs model", 64'(ok_p), 64'd1);
            chk(ok_m, "R11/R6 source mask vs model", 64'(ok_m), 64'd1);
            chk(rd_data === 32'd0, "R7 read value", 64'(rd_data), 64'd0);
        end
    end

    task automatic write_req(int cpu, logic [31:0] data);
        wr_en   = 1'b1;
        wr_cpu  = 3'(cpu);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic clear_req(int d, int i, int s);
        clr_en  = 1'b1;
        clr_dst = 3'(d);
        clr_id  = 4'(i);
        clr_src = 3'(s);
        @(negedge clk);
        clr_en  = 1'b0;
    endtask

    function automatic logic [31:0] word(int mode, int list, int id);
        return (32'(mode) << 24) | (32'(list) << 16) | 32'(id);
    endfunction

    initial begin
        logic [NC*NS-1:0]    p_save;
        logic [NC*NS*NC-1:0] m_save;
        repeat (3) @(negedge clk);
        chk(pend_o === '0, "R10 pending after reset", 64'(pend_o[63:0]), 64'd0);
        chk(src_mask_o === '0, "R10 masks after reset", 64'(src_mask_o[63:0]), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: explicit list
        write_req(0, word(0, 8'h06, 5));
        chk(pb(1,5) && pb(2,5) && !pb(0,5) && !pb(3,5), "R2 list targets",
            64'({pb(3,5),pb(2,5),pb(1,5),pb(0,5)}), 64'h6);
        chk(mb(1,5) == 8'h01, "R6 writer recorded", 64'(mb(1,5)), 64'h01);

        // R2: empty list and list outside online CPUs
        p_save = pend_o; m_save = src_mask_o;
        write_req(1, word(0, 8'h00, 9));
        write_req(1, word(0, 8'hF0, 9));
        chk(pend_o === p_save && src_mask_o === m_save, "R2 no online target no change",
            64'(pend_o[63:0]), 64'(p_save[63:0]));

        // R3: all but self
        write_req(2, word(1, 8'hFF, 3));
        chk({pb(4,3),pb(3,3),pb(2,3),pb(1,3),pb(0,3)} == 5'b01011, "R3 others",
            64'({pb(4,3),pb(3,3),pb(2,3),pb(1,3),pb(0,3)}), 64'b01011);
        chk(mb(0,3) == 8'h04, "R3 source is writer", 64'(mb(0,3)), 64'h04);

        // R4: self only
        write_req(3, word(2, 8'h0F, 15));
        chk(pb(3,15) && !pb(0,15) && !pb(1,15) && !pb(2,15), "R4 self only",
            64'({pb(3,15),pb(2,15),pb(1,15),pb(0,15)}), 64'h8);

        // R5: reserved mode
        p_save = pend_o; m_save = src_mask_o;
        write_req(1, word(3, 8'hFF, 2));
        chk(pend_o === p_save && src_mask_o === m_save, "R5 reserved mode",
            64'(pend_o[63:0]), 64'(p_save[63:0]));

        // R1/R6: junk in unused bits, second source accumulates
        write_req(3, word(0, 8'h02, 5) | 32'hFC00_ABC0);
        chk(mb(1,5) == 8'h09, "R1/R6 sources accumulate", 64'(mb(1,5)), 64'h09);

        // R8: clear one source at a time
        clear_req(1, 5, 0);
        chk(pb(1,5) && mb(1,5) == 8'h08, "R8 pending held",
            64'({pb(1,5), mb(1,5)}), 64'h108);
        clear_req(1, 5, 3);
        chk(!pb(1,5) && mb(1,5) == 8'h00, "R8 pending dropped",
            64'({pb(1,5), mb(1,5)}), 64'h000);

        // R9: set and clear of the same bit together
        clr_en = 1'b1; clr_dst = 3'd2; clr_id = 4'd7; clr_src = 3'd2;
        write_req(2, word(2, 8'h00, 7));
        clr_en = 1'b0;
        chk(pb(2,7) && mb(2,7) == 8'h04, "R9 set wins", 64'({pb(2,7), mb(2,7)}), 64'h104);

        // random phase with all CPUs online
        online_cnt = 4'd8;
        @(negedge clk);
        for (int k = 0; k < 400; k++) begin
            wr_en   = ($urandom_range(0, 2) != 0);
            wr_cpu  = 3'($urandom_range(0, 7));
            wr_data = $urandom;
            clr_en  = ($urandom_range(0, 1) != 0);
            clr_dst = 3'($urandom_range(0, 7));
            clr_id  = 4'($urandom_range(0, 15));
            clr_src = 3'($urandom_range(0, 7));
            @(negedge clk);
        end
        wr_en = 1'b0; clr_en = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule